// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block sits beside the sequencer of an 8-bit processor core and decides, each time the core reaches an instruction boundary, whether it must enter an interrupt handler instead of fetching the next opcode. It watches three request lines. The non-maskable request is captured on a rising edge into a pending flag. The fast request and the normal request are sampled as levels and are gated by the core's two inhibit bits.

When it accepts a request, it tells the core which vector address to read the new program counter from. It also gives the stack frame kind (full register set or program counter plus condition codes only), whether the push can be skipped because a wait instruction already stacked the state, the cycle cost of the entry, and the updated entire-state and inhibit bits. It also holds the wait flag and the sync flag. The sync flag drops as soon as any request appears, including a masked one, so the core can leave its idle loop.

All request inputs pass through a two-flop synchronizer first. Decisions are made only on the cycle in which the core raises its one-cycle boundary strobe. The result appears on registered outputs one clock later.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request taken, take is 0, vector_addr is 16'hFFFE, cc_i_out and cc_f_out are 1, cc_e_out, frame_full, push_skip and cost are 0, and in_wait and in_sync are 0.
- R2: When several requests qualify on the same boundary, the non-maskable one wins over the fast one, and the fast one wins over the normal one.
- R3: A rising edge of nmi_req sets a pending flag only once the arm flag is set. The arm flag is set from the cycle after the first sp_wr pulse and is cleared by reset. Edges before arming are dropped, and a request held high is taken only once.
- R4: A fast request is taken only while cc_f_in is 0. A normal request is taken only while cc_i_in is 0. A masked request produces no take.
- R5: A non-maskable entry gives vector 16'hFFFC, frame_full=1 and cost 19. A fast entry gives vector 16'hFFF6, frame_full=0 and cost 10. A normal entry gives vector 16'hFFF8, frame_full=1 and cost 19.
- R6: On every entry cc_i_out becomes 1. cc_f_out becomes 1 for non-maskable and fast entries and keeps cc_f_in for a normal entry. cc_e_out equals frame_full when the state is not already stacked.
- R7: A wait_enter pulse sets in_wait. An entry taken while in_wait is 1 reports push_skip=1 and passes cc_e_in through to cc_e_out, and in_wait returns to 0 after that entry.
- R8: A sync_enter pulse sets in_sync. in_sync clears once any synchronized request is present (pending non-maskable, fast level or normal level), even when masked.
- R9: take is 1 only in the cycle after a cycle with boundary=1. With boundary low, no entry is taken and take lasts a single cycle.
- R10: If a new non-maskable edge is detected in the same cycle that a pending non-maskable request is taken, the pending flag stays set and the next boundary takes it again.
- R11: A request level that changes at a pin is first seen by a boundary sampled on the third rising edge after the change. A boundary sampled on the second edge still sees the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, edge sensitive, asynchronous |
| firq_req | input | 1 | Fast request level, asynchronous |
| irq_req | input | 1 | Normal request level, asynchronous |
| sp_wr | input | 1 | Pulse when the core writes its hardware stack pointer |
| boundary | input | 1 | One-cycle instruction boundary strobe |
| cc_e_in | input | 1 | Current entire-state bit |
| cc_f_in | input | 1 | Current fast-request inhibit bit |
| cc_i_in | input | 1 | Current normal-request inhibit bit |
| wait_enter | input | 1 | Pulse: core has stacked its state and waits |
| sync_enter | input | 1 | Pulse: core enters the sync idle state |
| take | output | 1 | One-cycle pulse: enter the interrupt now |
| vector_addr | output | 16 | Address of the big-endian new program counter |
| frame_full | output | 1 | 1 = full register frame, 0 = short frame |
| push_skip | output | 1 | 1 = state already stacked, skip the push |
| cost | output | 5 | Cycle cost of this entry |
| cc_e_out | output | 1 | Entire-state bit after entry |
| cc_f_out | output | 1 | Fast inhibit bit after entry |
| cc_i_out | output | 1 | Normal inhibit bit after entry |
| in_wait | output | 1 | Wait-with-state-stacked flag |
| in_sync | output | 1 | Sync idle flag |

## Verification
A lost or stuck pending flag shows at the next boundary as a missing or extra take with vector 16'hFFFC, so the bench strobes repeatedly after edges, including an edge timed to land on the cycle its predecessor is taken. A wrong priority or a broken mask shows as a wrong vector or cost one clock after the boundary. Random levels and condition-code bits are compared against a bench model on every strobe. A stale wait or sync flag shows at once on in_wait, in_sync and push_skip.

// File: rtl/irq_entry_pkg.sv
// Package: shared source encoding and vector addresses for the interrupt
// entry controller. Assumes a 16-bit address space with vectors at the top.
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_FIRQ = 2'd2,
        SRC_IRQ  = 2'd3
    } irq_src_e;

    localparam logic [15:0] VEC_RESET = 16'hFFFE;
    localparam logic [15:0] VEC_NMI   = 16'hFFFC;
    localparam logic [15:0] VEC_IRQ   = 16'hFFF8;
    localparam logic [15:0] VEC_FIRQ  = 16'hFFF6;

endpackage

// File: rtl/irq_req_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous request
// lines. Assumes each line is a slow level; no pulse stretching is done.
module irq_req_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw inputs into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= d;
            end
        end else begin : g_next
            // Shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/irq_nmi_latch.sv
// Module: rising-edge capture of the non-maskable request with an arm gate.
// Assumes lvl is already synchronized. A set from a new edge wins over a
// clear in the same cycle, so no edge is lost at entry.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic arm_wr,
    input  logic clear,
    output logic pending,
    output logic armed
);

    logic lvl_prev;
    logic edge_seen;

    assign edge_seen = lvl && !lvl_prev;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    // The arm flag is sticky after the first stack pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (arm_wr) armed <= 1'b1;
    end

    // The pending flag is set by an armed edge, else cleared by the taker.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pending <= 1'b0;
        else if (edge_seen && armed)   pending <= 1'b1;
        else if (clear)                pending <= 1'b0;
    end

endmodule

// File: rtl/irq_entry_arb.sv
// Module: combinational fixed-priority choice among the qualified requests.
// Assumes the inputs are synchronized and the inhibit bits are current.
module irq_entry_arb
    import irq_entry_pkg::*;
(
    input  logic     nmi_pend,
    input  logic     firq_lvl,
    input  logic     irq_lvl,
    input  logic     inh_f,
    input  logic     inh_i,
    output irq_src_e src
);

    // Pick the highest-priority qualified request.
    always_comb begin
        if (nmi_pend)                src = SRC_NMI;
        else if (firq_lvl && !inh_f) src = SRC_FIRQ;
        else if (irq_lvl && !inh_i)  src = SRC_IRQ;
        else                         src = SRC_NONE;
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
// Module: interrupt entry controller top. Decides entry on the boundary
// strobe and registers the entry parameters for the core. Assumes the core
// strobes boundary for one cycle and samples outputs the cycle after.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int COST_W     = 5,
    parameter int COST_FULL  = 19,
    parameter int COST_SHORT = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              firq_req,
    input  logic              irq_req,
    input  logic              sp_wr,
    input  logic              boundary,
    input  logic              cc_e_in,
    input  logic              cc_f_in,
    input  logic              cc_i_in,
    input  logic              wait_enter,
    input  logic              sync_enter,
    output logic              take,
    output logic [15:0]       vector_addr,
    output logic              frame_full,
    output logic              push_skip,
    output logic [COST_W-1:0] cost,
    output logic              cc_e_out,
    output logic              cc_f_out,
    output logic              cc_i_out,
    output logic              in_wait,
    output logic              in_sync
);

    localparam int NREQ = 3;
    localparam logic [COST_W-1:0] C_FULL  = COST_W'(COST_FULL);
    localparam logic [COST_W-1:0] C_SHORT = COST_W'(COST_SHORT);

    logic [NREQ-1:0] req_s;
    logic            nmi_pend;
    logic            nmi_armed;
    irq_src_e        src;
    logic            take_now;
    logic            req_any;

    irq_req_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({irq_req, firq_req, nmi_req}),
        .q     (req_s)
    );

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (req_s[0]),
        .arm_wr  (sp_wr),
        .clear   (take_now && (src == SRC_NMI)),
        .pending (nmi_pend),
        .armed   (nmi_armed)
    );

    irq_entry_arb u_arb (
        .nmi_pend (nmi_pend),
        .firq_lvl (req_s[1]),
        .irq_lvl  (req_s[2]),
        .inh_f    (cc_f_in),
        .inh_i    (cc_i_in),
        .src      (src)
    );

    assign take_now = boundary && (src != SRC_NONE);
    assign req_any  = nmi_pend || req_s[1] || req_s[2];

    // Register the entry decision and its parameters for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take        <= 1'b0;
            vector_addr <= VEC_RESET;
            frame_full  <= 1'b0;
            push_skip   <= 1'b0;
            cost        <= '0;
            cc_e_out    <= 1'b0;
            cc_f_out    <= 1'b1;
            cc_i_out    <= 1'b1;
        end else begin
            take <= take_now;
            if (take_now) begin
                push_skip <= in_wait;
                cc_i_out  <= 1'b1;
                unique case (src)
                    SRC_NMI: begin
                        vector_addr <= VEC_NMI;
                        frame_full  <= 1'b1;
                        cost        <= C_FULL;
                        cc_f_out    <= 1'b1;
                        cc_e_out    <= in_wait ? cc_e_in : 1'b1;
                    end
                    SRC_FIRQ: begin
                        vector_addr <= VEC_FIRQ;
                        frame_full  <= 1'b0;
                        cost        <= C_SHORT;
                        cc_f_out    <= 1'b1;
                        cc_e_out    <= in_wait ? cc_e_in : 1'b0;
                    end
                    default: begin
                        vector_addr <= VEC_IRQ;
                        frame_full  <= 1'b1;
                        cost        <= C_FULL;
                        cc_f_out    <= cc_f_in;
                        cc_e_out    <= in_wait ? cc_e_in : 1'b1;
                    end
                endcase
            end
        end
    end

    // Track the stacked-wait flag: set by the core, cleared by entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          in_wait <= 1'b0;
        else if (take_now)   in_wait <= 1'b0;
        else if (wait_enter) in_wait <= 1'b1;
    end

    // Track the sync idle flag: any request, masked or not, ends it.
    always_ff @(posedge clk) begin
        if (!rst_n)          in_sync <= 1'b0;
        else if (req_any)    in_sync <= 1'b0;
        else if (sync_enter) in_sync <= 1'b1;
    end

endmodule

// File: rtl/irq_entry_chk.sv
// Module: assertion checker for the interrupt entry controller, attached
// by bind. Observes ports and the arm/pending state of the edge latch.
module irq_entry_chk #(
    parameter int COST_W     = 5,
    parameter int COST_SHORT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              cc_f_in,
    input logic              cc_i_in,
    input logic              take,
    input logic [15:0]       vector_addr,
    input logic              frame_full,
    input logic [COST_W-1:0] cost,
    input logic              cc_i_out,
    input logic              in_wait,
    input logic              armed,
    input logic              pend
);

    assert_take_after_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));

    assert_short_frame_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !frame_full) |-> (vector_addr == 16'hFFF6 && cost == COST_W'(COST_SHORT)));

    assert_irq_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vector_addr == 16'hFFF8) |-> $past(!cc_i_in));

    assert_firq_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vector_addr == 16'hFFF6) |-> $past(!cc_f_in));

    assert_no_pend_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !pend);

    assert_wait_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !in_wait);

    assert_i_set_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cc_i_out);

endmodule

bind irq_entry_ctrl irq_entry_chk #(.COST_W(COST_W), .COST_SHORT(COST_SHORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (boundary),
    .cc_f_in     (cc_f_in),
    .cc_i_in     (cc_i_in),
    .take        (take),
    .vector_addr (vector_addr),
    .frame_full  (frame_full),
    .cost        (cost),
    .cc_i_out    (cc_i_out),
    .in_wait     (in_wait),
    .armed       (nmi_armed),
    .pend        (nmi_pend)
);

// File: tb/irq_entry_ctrl_test.sv
`timescale 1ns/1ps
module irq_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 0, firq_req = 0, irq_req = 0, sp_wr = 0, boundary = 0;
    logic        cc_e_in = 0, cc_f_in = 1, cc_i_in = 1, wait_enter = 0, sync_enter = 0;
    logic        take, frame_full, push_skip, cc_e_out, cc_f_out, cc_i_out, in_wait, in_sync;
    logic [15:0] vector_addr;
    logic [4:0]  cost;

    int checks = 0;
    int fails  = 0;
    bit model_wait = 0;

    always #2.5 clk = ~clk;

    irq_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .firq_req(firq_req),
        .irq_req(irq_req), .sp_wr(sp_wr), .boundary(boundary), .cc_e_in(cc_e_in),
        .cc_f_in(cc_f_in), .cc_i_in(cc_i_in), .wait_enter(wait_enter),
        .sync_enter(sync_enter), .take(take), .vector_addr(vector_addr),
        .frame_full(frame_full), .push_skip(push_skip), .cost(cost),
        .cc_e_out(cc_e_out), .cc_f_out(cc_f_out), .cc_i_out(cc_i_out),
        .in_wait(in_wait), .in_sync(in_sync)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Strobe boundary for one cycle; return at the negedge after the edge.
    task automatic strobe();
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
    endtask

    // Expected source: 0 none, 1 nmi, 2 fast, 3 normal.
    function automatic int exp_src(input bit np, input bit fq, input bit iq,
                                   input bit f, input bit i);
        if (np) return 1;
        if (fq && !f) return 2;
        if (iq && !i) return 3;
        return 0;
    endfunction

    task automatic chk_entry(input string tag, input int src, input bit skip, input bit ein, input bit fin);
        chk({tag, " take"}, take, src != 0);
        if (src != 0) begin
            chk({tag, " vector"}, vector_addr, src == 1 ? 16'hFFFC : src == 2 ? 16'hFFF6 : 16'hFFF8);
            chk({tag, " frame"}, frame_full, src != 2);
            chk({tag, " cost"}, cost, src == 2 ? 10 : 19);
            chk({tag, " push_skip"}, push_skip, skip);
            chk({tag, " e_out"}, cc_e_out, skip ? ein : (src != 2));
            chk({tag, " f_out"}, cc_f_out, src == 3 ? fin : 1'b1);
            chk({tag, " i_out"}, cc_i_out, 1'b1);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state.
        cyc(3);
        chk("R1 take in reset", take, 0);
        chk("R1 vector in reset", vector_addr, 16'hFFFE);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 take", take, 0);
        chk("R1 vector", vector_addr, 16'hFFFE);
        chk("R1 i_out", cc_i_out, 1);
        chk("R1 f_out", cc_f_out, 1);
        chk("R1 e/frame/skip/cost", {cc_e_out, frame_full, push_skip, cost}, 0);
        chk("R1 wait/sync", {in_wait, in_sync}, 0);

        // R3: edge before arming is dropped.
        nmi_req = 1; cyc(4); nmi_req = 0; cyc(4);
        strobe();
        chk("R3 unarmed edge ignored", take, 0);

        // R3: arm then edge; held level taken once.
        @(negedge clk) sp_wr = 1; @(negedge clk) sp_wr = 0;
        nmi_req = 1; cyc(4);
        strobe();
        chk_entry("R3 armed nmi", 1, 0, 0, 1);
        @(negedge clk);
        chk("R9 take single cycle", take, 0);
        strobe();
        chk("R3 held level not retaken", take, 0);
        nmi_req = 0; cyc(4);

        // R2: all three at once, all unmasked.
        cc_i_in = 0; cc_f_in = 0;
        nmi_req = 1; firq_req = 1; irq_req = 1; cyc(4);
        strobe();
        chk_entry("R2 nmi over others", 1, 0, 0, 0);
        strobe();
        chk_entry("R2 fast over normal R5 R6", 2, 0, 0, 0);
        cc_f_in = 1;
        strobe();
        chk_entry("R6 normal keeps f=1", 3, 0, 0, 1);
        cc_f_in = 0; firq_req = 0; cyc(3);
        strobe();
        chk_entry("R6 normal keeps f=0", 3, 0, 0, 0);

        // R4: both levels masked.
        firq_req = 1; cc_i_in = 1; cc_f_in = 1; cyc(3);
        strobe();
        chk("R4 masked no take", take, 0);

        // R9: no boundary, no entry.
        cc_i_in = 0; cc_f_in = 0;
        cyc(3);
        chk("R9 no strobe no take", take, 0);
        cyc(2);
        chk("R9 no strobe still none", take, 0);

        // R7: stacked wait skips push and keeps E.
        @(negedge clk) wait_enter = 1; @(negedge clk) wait_enter = 0;
        chk("R7 in_wait set", in_wait, 1);
        cc_e_in = 1;
        strobe();
        chk_entry("R7 fast with wait", 2, 1, 1, 0);
        chk("R7 in_wait cleared", in_wait, 0);
        cc_e_in = 0;

        // R8: sync exits on a masked request.
        firq_req = 0; irq_req = 0; nmi_req = 0; cc_i_in = 1; cc_f_in = 1; cyc(4);
        @(negedge clk) sync_enter = 1; @(negedge clk) sync_enter = 0;
        cyc(3);
        chk("R8 in_sync held", in_sync, 1);
        irq_req = 1; cyc(4);
        chk("R8 masked request ends sync", in_sync, 0);
        irq_req = 0; cyc(4);

        // R11: two-flop latency of a level.
        cc_f_in = 0;
        @(negedge clk) firq_req = 1;
        boundary = 1;
        @(negedge clk) boundary = 0;
        chk("R11 level not yet visible", take, 0);
        boundary = 1;
        @(negedge clk) boundary = 0;
        chk("R11 second edge still old", take, 0);
        boundary = 1;
        @(negedge clk) boundary = 0;
        chk("R11 third edge sees level", take, 1);
        firq_req = 0; cc_f_in = 1; cyc(4);

        // R10: a new edge on the cycle the pending one is taken.
        nmi_req = 1; cyc(4); nmi_req = 0; cyc(4);
        @(negedge clk) nmi_req = 1;
        cyc(2);
        boundary = 1;
        @(negedge clk) boundary = 0;
        chk_entry("R10 first nmi", 1, 0, 0, 1);
        strobe();
        chk_entry("R10 re-edge kept", 1, 0, 0, 1);
        strobe();
        chk("R10 then empty", take, 0);
        nmi_req = 0; cyc(4);

        // Random levels and masks against the model.
        void'($urandom(32'd1234));
        model_wait = 0;
        for (int n = 0; n < 300; n++) begin
            firq_req = $urandom_range(0, 1);
            irq_req  = $urandom_range(0, 1);
            cc_f_in  = $urandom_range(0, 1);
            cc_i_in  = $urandom_range(0, 1);
            cc_e_in  = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk) wait_enter = 1; @(negedge clk) wait_enter = 0;
                model_wait = 1;
            end
            cyc(3);
            begin
                int s;
                s = exp_src(0, firq_req, irq_req, cc_f_in, cc_i_in);
                strobe();
                chk_entry("R2 R4 R5 R6 R7 random", s, model_wait, cc_e_in, cc_f_in);
                if (s != 0) model_wait = 0;
                chk("R7 random in_wait", in_wait, model_wait);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule